// File: doc/BRIEF.md
# Priority Peripheral Pin Crossbar

This block places the signals of several on-chip digital peripherals onto a row of general-purpose port pins. The peripherals are visited in a fixed order: UART0, SMBus, UART1, external interrupt 0, external interrupt 1. Each enabled peripheral takes the next free pins, counting upward from pin 0. A per-pin skip mask keeps chosen pins out of the allocation so they stay free for analog use. A peripheral's signals are always placed together, so a pair can never be split or half-placed.

The allocation is worked out combinationally from the configuration inputs. It is then registered once per clock, so the per-pin routing only changes on a clock edge. The registered selection drives a multiplexer on every pin. It picks one of three sources: a peripheral's output value, the port data register, or nothing at all for a pin that carries a peripheral input. A global enable, registered with the selection, holds every output driver off until it is set. The pins also feed back to the peripherals through an input-routing path.

Top module: `xbar_crossbar`

## Requirements
- R1: While reset is held, and on the first cycle after reset before any clock edge, every pin selection code is 0, every output enable is 0 and overflow is 0.
- R2: `periph_en` bits select the peripherals: bit 0 is UART0, bit 1 is SMBus, bit 2 is UART1, bit 3 is interrupt 0 and bit 4 is interrupt 1. Each pin has a 4-bit code in `pin_sel[4p+3:4p]` with these values: 1 UART0 TX, 2 UART0 RX, 3 SMBus data, 4 SMBus clock, 5 UART1 TX, 6 UART1 RX, 7 interrupt 0, 8 interrupt 1, 0 none. Enabled signals take consecutive free pins in ascending code order, starting from the lowest free pin. Each code appears on at most one pin.
- R3: A pin whose `skip_mask` bit is 1 always has code 0. Allocation carries on at the next pin that is not skipped.
- R4: A peripheral is placed only if all of its signals fit on the free pins left. If it does not fit, that peripheral and every enabled peripheral after it in priority order stay unplaced, and `overflow` is 1.
- R5: While the registered global enable is 0, every bit of `pin_oe` is 0.
- R6: A pin with an input code (2, 6, 7 or 8) has `pin_is_in` set, `pin_oe` at 0 and `pin_dout` at 0, whatever `port_data` holds.
- R7: A pin with an output code (1, 3, 4 or 5) has `pin_is_out` set. Its `pin_dout` equals `periph_out[code-1]` and its `pin_oe` equals the registered global enable.
- R8: A pin with code 0 drives `pin_dout` from its `port_data` bit, with `pin_oe` equal to the registered global enable.
- R9: `periph_in[s]` equals `pin_in` of the pin holding code s+1 while the registered global enable is 1. Otherwise it is 1.
- R10: A change to `periph_en`, `skip_mask` or `xbar_en` reaches the outputs at the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| periph_en | input | 5 | Peripheral enables, in priority order |
| skip_mask | input | NUM_PINS | 1 = pin excluded from allocation |
| port_data | input | NUM_PINS | Port data register value for pins with no peripheral |
| periph_out | input | 8 | Output value of each peripheral signal, indexed by code-1 |
| pin_in | input | NUM_PINS | Level seen on each pin |
| pin_sel | output | NUM_PINS*4 | Registered per-pin selection code |
| pin_is_in | output | NUM_PINS | Pin carries a peripheral input |
| pin_is_out | output | NUM_PINS | Pin is driven by a peripheral |
| pin_oe | output | NUM_PINS | Per-pin output driver enable |
| pin_dout | output | NUM_PINS | Per-pin output value |
| periph_in | output | 8 | Pin level routed to each peripheral signal |
| overflow | output | 1 | Some enabled peripheral could not be placed |

## Verification
The bench builds the block with its default of 32 pins. At that size all eight signals fit with room to spare, so overflow appears only when the skip mask leaves few free pins. The directed cases therefore skip all but three pins to split a pair at the boundary, and skip every pin to reach total exhaustion. Random configurations with dense skip masks then mix these cases with ordinary placements, and a behavioural model built on a queue of free pins is compared against every output on every cycle.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int NSIG = 8;
    localparam int NGRP = 5;
    localparam int SELW = $clog2(NSIG + 1);

    // signal index s carries selection code s+1
    function automatic int grp_of(int s);
        case (s)
            0, 1:    return 0;
            2, 3:    return 1;
            4, 5:    return 2;
            6:       return 3;
            default: return 4;
        endcase
    endfunction

    function automatic int grp_size(int g);
        return (g < 3) ? 2 : 1;
    endfunction

    function automatic int grp_first(int g);
        return (g < 3) ? 2 * g : g + 3;
    endfunction

    function automatic logic sig_is_input(int s);
        return (s == 1) || (s == 5) || (s == 6) || (s == 7);
    endfunction
endpackage

// File: rtl/xbar_alloc.sv
module xbar_alloc
    import xbar_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NGRP-1:0]                periph_en,
    input  logic [NUM_PINS-1:0]            skip_mask,
    output logic [NUM_PINS-1:0][SELW-1:0]  sel,
    output logic                           overflow
);
    localparam int CW = $clog2(NUM_PINS + 1);
    localparam int BW = ((CW > SELW) ? CW : SELW) + 1;

    logic [CW-1:0] rank [NUM_PINS];
    logic [CW-1:0] free_total;
    logic [BW-1:0] gbase [NGRP];
    logic          gfit  [NGRP];
    logic [BW-1:0] sidx  [NSIG];
    logic          svalid[NSIG];

    always_comb begin
        logic [CW-1:0] cnt;
        logic [BW-1:0] acc;
        // rank of a pin = number of free pins below it
        cnt = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            rank[p] = cnt;
            cnt = cnt + CW'(!skip_mask[p]);
        end
        free_total = cnt;

        // groups take contiguous free ranks in priority order
        acc = '0;
        overflow = 1'b0;
        for (int g = 0; g < NGRP; g++) begin
            gbase[g] = acc;
            gfit[g]  = periph_en[g] && ((acc + BW'(grp_size(g))) <= BW'(free_total));
            if (periph_en[g]) begin
                acc = acc + BW'(grp_size(g));
                if (!gfit[g]) overflow = 1'b1;
            end
        end

        for (int s = 0; s < NSIG; s++) begin
            svalid[s] = gfit[grp_of(s)];
            sidx[s]   = gbase[grp_of(s)] + BW'(s - grp_first(grp_of(s)));
        end

        for (int p = 0; p < NUM_PINS; p++) begin
            sel[p] = '0;
            for (int s = 0; s < NSIG; s++) begin
                if (!skip_mask[p] && svalid[s] && (sidx[s] == BW'(rank[p])))
                    sel[p] = SELW'(s + 1);
            end
        end
    end
endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux
    import xbar_pkg::*;
(
    input  logic [SELW-1:0] sel,
    input  logic            en,
    input  logic            gpio_bit,
    input  logic [NSIG-1:0] periph_out,
    output logic            oe,
    output logic            dout,
    output logic            is_in,
    output logic            is_out
);
    always_comb begin
        is_in  = 1'b0;
        is_out = 1'b0;
        dout   = gpio_bit;
        oe     = en;
        for (int s = 0; s < NSIG; s++) begin
            if (sel == SELW'(s + 1)) begin
                if (sig_is_input(s)) begin
                    is_in = 1'b1;
                    oe    = 1'b0;
                    dout  = 1'b0;
                end else begin
                    is_out = 1'b1;
                    dout   = periph_out[s];
                    oe     = en;
                end
            end
        end
    end
endmodule

// File: rtl/xbar_crossbar.sv
module xbar_crossbar
    import xbar_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xbar_en,
    input  logic [NGRP-1:0]          periph_en,
    input  logic [NUM_PINS-1:0]      skip_mask,
    input  logic [NUM_PINS-1:0]      port_data,
    input  logic [NSIG-1:0]          periph_out,
    input  logic [NUM_PINS-1:0]      pin_in,
    output logic [NUM_PINS*SELW-1:0] pin_sel,
    output logic [NUM_PINS-1:0]      pin_is_in,
    output logic [NUM_PINS-1:0]      pin_is_out,
    output logic [NUM_PINS-1:0]      pin_oe,
    output logic [NUM_PINS-1:0]      pin_dout,
    output logic [NSIG-1:0]          periph_in,
    output logic                     overflow
);
    typedef struct packed {
        logic [NUM_PINS-1:0][SELW-1:0] sel;
        logic                          en;
        logic                          ovf;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_PINS-1:0][SELW-1:0] alloc_sel;
    logic                          alloc_ovf;

    xbar_alloc #(.NUM_PINS(NUM_PINS)) alloc_i (
        .periph_en (periph_en),
        .skip_mask (skip_mask),
        .sel       (alloc_sel),
        .overflow  (alloc_ovf)
    );

    always_comb begin
        state_d     = state_q;
        state_d.sel = alloc_sel;
        state_d.en  = xbar_en;
        state_d.ovf = alloc_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        xbar_pin_mux mux_i (
            .sel        (state_q.sel[p]),
            .en         (state_q.en),
            .gpio_bit   (port_data[p]),
            .periph_out (periph_out),
            .oe         (pin_oe[p]),
            .dout       (pin_dout[p]),
            .is_in      (pin_is_in[p]),
            .is_out     (pin_is_out[p])
        );
    end

    always_comb begin
        for (int s = 0; s < NSIG; s++) begin
            periph_in[s] = 1'b1;
            for (int p = 0; p < NUM_PINS; p++) begin
                if (state_q.en && (state_q.sel[p] == SELW'(s + 1)))
                    periph_in[s] = pin_in[p];
            end
        end
    end

    assign pin_sel  = state_q.sel;
    assign overflow = state_q.ovf;
endmodule

// File: rtl/xbar_crossbar_chk.sv
module xbar_crossbar_chk
    import xbar_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     xbar_en,
    input logic [NGRP-1:0]          periph_en,
    input logic [NUM_PINS-1:0]      skip_mask,
    input logic [NUM_PINS*SELW-1:0] pin_sel,
    input logic [NUM_PINS-1:0]      pin_is_in,
    input logic [NUM_PINS-1:0]      pin_oe
);
    logic [1:0]          age;
    logic                dup;
    logic [NUM_PINS-1:0] asg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    always_comb begin
        dup = 1'b0;
        for (int c = 1; c <= NSIG; c++) begin
            int n;
            n = 0;
            for (int p = 0; p < NUM_PINS; p++)
                if (pin_sel[p*SELW +: SELW] == SELW'(c)) n++;
            if (n > 1) dup = 1'b1;
        end
        for (int p = 0; p < NUM_PINS; p++)
            asg[p] = (pin_sel[p*SELW +: SELW] != '0);
    end

    a_r2_code_unique: assert property (@(posedge clk) disable iff (!rst_n)
        !dup);

    a_r3_skip_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) |-> (($past(skip_mask) & asg) == '0));

    a_r5_disabled_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((age != 2'd0) && !$past(xbar_en)) |-> (pin_oe == '0));

    a_r6_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_is_in & pin_oe) == '0);

    a_r10_hold_when_static: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd2) && ($past(skip_mask) == skip_mask) && ($past(periph_en) == periph_en))
        |=> $stable(pin_sel));
endmodule

bind xbar_crossbar xbar_crossbar_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xbar_en   (xbar_en),
    .periph_en (periph_en),
    .skip_mask (skip_mask),
    .pin_sel   (pin_sel),
    .pin_is_in (pin_is_in),
    .pin_oe    (pin_oe)
);

// File: tb/xbar_crossbar_tb_top.sv
`timescale 1ns/1ps
module xbar_crossbar_tb_top;
    localparam int NP = 32;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xbar_en = 1'b0;
    logic [4:0]    periph_en = '0;
    logic [NP-1:0] skip_mask = '0;
    logic [NP-1:0] port_data = '0;
    logic [NS-1:0] periph_out = '0;
    logic [NP-1:0] pin_in = '1;
    logic [NP*4-1:0] pin_sel;
    logic [NP-1:0] pin_is_in, pin_is_out, pin_oe, pin_dout;
    logic [NS-1:0] periph_in;
    logic          overflow;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_sel [NP];
    bit m_en  = 0;
    bit m_ovf = 0;

    always #5 clk = ~clk;

    xbar_crossbar #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .periph_en(periph_en),
        .skip_mask(skip_mask), .port_data(port_data), .periph_out(periph_out),
        .pin_in(pin_in), .pin_sel(pin_sel), .pin_is_in(pin_is_in),
        .pin_is_out(pin_is_out), .pin_oe(pin_oe), .pin_dout(pin_dout),
        .periph_in(periph_in), .overflow(overflow)
    );

    // behavioural reference: queue of free pins, groups in priority order
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) m_sel[p] = 0;
            m_en  = 0;
            m_ovf = 0;
        end else begin
            int freeq[$];
            int gsz[5];
            int ptr, code;
            gsz = '{2, 2, 2, 1, 1};
            freeq = {};
            for (int p = 0; p < NP; p++) begin
                m_sel[p] = 0;
                if (!skip_mask[p]) freeq.push_back(p);
            end
            ptr = 0; code = 1; m_ovf = 0;
            for (int g = 0; g < 5; g++) begin
                if (periph_en[g]) begin
                    if (ptr + gsz[g] <= freeq.size())
                        for (int k = 0; k < gsz[g]; k++) m_sel[freeq[ptr+k]] = code + k;
                    else
                        m_ovf = 1;
                    ptr += gsz[g];
                end
                code += gsz[g];
            end
            m_en = xbar_en;
        end
    end

    function automatic bit is_in_code(int c);
        return (c == 2) || (c == 6) || (c == 7) || (c == 8);
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [NP*4-1:0] e_sel;
        logic [NP-1:0] e_oe, e_do, e_in, e_out;
        logic [NS-1:0] e_pi;
        e_pi = '1;
        for (int p = 0; p < NP; p++) begin
            int c;
            c = m_sel[p];
            e_sel[p*4 +: 4] = 4'(c);
            e_in[p] = 0; e_out[p] = 0;
            if (c == 0) begin
                e_oe[p] = m_en; e_do[p] = port_data[p];
            end else if (is_in_code(c)) begin
                e_oe[p] = 0; e_do[p] = 0; e_in[p] = 1;
            end else begin
                e_oe[p] = m_en; e_do[p] = periph_out[c-1]; e_out[p] = 1;
            end
            if (c != 0 && m_en) e_pi[c-1] = pin_in[p];
        end
        chk(pin_sel == e_sel, "R2", "pin_sel", 0, 0);
        if (pin_sel != e_sel)
            $display("  R2 detail: actual %h expected %h", pin_sel, e_sel);
        chk(overflow == m_ovf, "R4", "overflow", overflow, m_ovf);
        chk(pin_oe == e_oe, "R5", "pin_oe", pin_oe, e_oe);
        chk(pin_is_in == e_in, "R6", "pin_is_in", pin_is_in, e_in);
        chk(pin_is_out == e_out, "R7", "pin_is_out", pin_is_out, e_out);
        chk(pin_dout == e_do, "R7", "pin_dout", pin_dout, e_do);
        chk(periph_in == e_pi, "R9", "periph_in", periph_in, e_pi);
    endtask

    // wait one cycle, then compare against the model before new stimulus
    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    function automatic int sel_of(int p);
        return int'(pin_sel[p*4 +: 4]);
    endfunction

    initial begin
        #(100000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        port_data = '1; periph_en = 5'h1F; xbar_en = 1;
        repeat (3) @(negedge clk);
        chk(pin_sel == '0, "R1", "pin_sel in reset", 0, 0);
        chk(pin_oe == '0, "R1", "pin_oe in reset", pin_oe, 0);
        chk(overflow == 0, "R1", "overflow in reset", overflow, 0);
        periph_en = 0; xbar_en = 0;
        rst_n = 1;
        #1;
        chk(pin_sel == '0 && pin_oe == '0, "R1", "state after release", pin_oe, 0);
        step();

        // R2: UART0 alone on pins 0,1; R6: RX pin never driven
        xbar_en = 1; periph_en = 5'h01; port_data = '1;
        step();
        chk(sel_of(0) == 1 && sel_of(1) == 2, "R2", "uart0 pins", sel_of(1), 2);
        chk(pin_is_in[1] && !pin_oe[1], "R6", "rx pin driver", pin_oe[1], 0);

        // R9: input routing follows pin 1
        pin_in = '1; pin_in[1] = 0;
        step();
        chk(periph_in[1] == 0, "R9", "uart0 rx low", periph_in[1], 0);
        chk(periph_in[5] == 1, "R9", "unplaced rx idle", periph_in[5], 1);

        // R2: everything enabled, codes 1..8 on pins 0..7
        periph_en = 5'h1F; pin_in = '1;
        step();
        chk(sel_of(7) == 8 && sel_of(8) == 0, "R2", "full set", sel_of(7), 8);

        // R3: skip pins 0 and 2
        skip_mask = 32'h0000_0005;
        step();
        chk(sel_of(1) == 1 && sel_of(3) == 2 && sel_of(4) == 3, "R3", "skip walk", sel_of(3), 2);
        chk(sel_of(2) == 0 && sel_of(9) == 8, "R3", "skipped pin idle", sel_of(2), 0);

        // R4: only pins 0..2 free; SMBus cannot fit, interrupt 0 dropped too
        skip_mask = ~32'h7; periph_en = 5'b01011;
        step();
        chk(overflow == 1, "R4", "overflow raised", overflow, 1);
        chk(sel_of(0) == 1 && sel_of(1) == 2 && sel_of(2) == 0, "R4", "split pair refused", sel_of(2), 0);

        // R4: all pins skipped
        skip_mask = '1;
        step();
        chk(overflow == 1 && pin_sel == '0, "R4", "no free pins", overflow, 1);

        // R8: no peripherals, port data drives pins
        skip_mask = '0; periph_en = 0; port_data = 32'hA5C3_0F96;
        step();
        chk(pin_dout == 32'hA5C3_0F96 && pin_oe == '1, "R8", "gpio fallback", pin_dout, 32'hA5C3_0F96);

        // R5: global enable off
        xbar_en = 0; periph_en = 5'h1F;
        step();
        chk(pin_oe == '0, "R5", "drivers held off", pin_oe, 0);

        // R10: change applies at the next edge only
        xbar_en = 1; periph_en = 5'h01;
        step(2);
        @(negedge clk);
        periph_en = 5'h10;
        #1;
        chk(sel_of(0) == 1, "R10", "before edge", sel_of(0), 1);
        step();
        chk(sel_of(0) == 8, "R10", "after edge", sel_of(0), 8);

        // R7: peripheral output values reach pins
        periph_en = 5'h07; periph_out = 8'b0001_0101;
        step();
        chk(pin_dout[0] == 1 && pin_dout[2] == 1 && pin_dout[3] == 0 && pin_is_out[4],
            "R7", "tx/sda/scl values", pin_dout[3:0], 4'b0101);

        // random mix
        for (int i = 0; i < 400; i++) begin
            xbar_en    = ($urandom_range(0, 7) != 0);
            periph_en  = 5'($urandom);
            skip_mask  = (i % 3 == 0) ? ~(32'h1 << $urandom_range(0, 31) | 32'h1 << $urandom_range(0, 31))
                                      : ($urandom & $urandom);
            port_data  = $urandom;
            periph_out = 8'($urandom);
            pin_in     = $urandom;
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule